// File: doc/BRIEF.md
# Auxiliary Serial Audio Output Port

This block is a stereo serial audio transmitter that always acts as the clock master. It drives its own bit clock, frame clock and serial data. Five processed 24-bit streams arrive as parallel words: channel A, channel B, a low-frequency sub channel, and the low-pass and high-pass halves of a channel-B crossover. Two independent 2-bit select inputs decide which stream is sent in the left slot and which in the right slot.

In analog-input mode the bit clock is divided down from the system clock. In digital-input mode the bit clock follows the incoming serial bit clock, or runs at half its rate when the input frame rate is 96 kHz. Every frame holds two slots of `SLOT_W` bit periods. Each slot carries a `SAMPLE_W`-bit word, MSB first, followed by zero padding. A format input selects between left-justified and I2S framing.

An enable input, together with two power-down inputs that apply only in analog mode, holds all three outputs at constant 0. Selects and samples are latched together once per frame, so the word being sent is never torn.

Top module: `aux_audio_tx`

## Requirements
- R1: While `en` is 0, and during reset, `aux_bclk`, `aux_lrck` and `aux_sd` are all 0.
- R2: With `analog_mode`=1, setting `pd_adc` or `pd_all` forces all three outputs to 0 even when `en`=1. With `analog_mode`=0 both power-down inputs have no effect.
- R3: In analog mode `aux_bclk` has a period of `ANA_DIV` system clocks, high for `ANA_DIV/2` of them.
- R4: A frame lasts 2*`SLOT_W` bit periods, so `aux_lrck` rises once every 2*`SLOT_W` bit periods.
- R5: With `fmt_i2s`=0 (left-justified), `aux_lrck` is 1 for the left slot and 0 for the right slot. The word MSB is in the first bit period of its slot, and the `SLOT_W`-`SAMPLE_W` trailing bits of each slot are 0.
- R6: With `fmt_i2s`=1 (I2S), `aux_lrck` is 0 for the left slot and 1 for the right slot. `aux_lrck` changes one bit period before the MSB of the word it marks, so within a frame of positions 0..63 it is 1 exactly at positions 31..62.
- R7: `sel_l` codes: 00 sends `ch_a`, 01 sends `ch_b`, 10 sends `ch_sub`, 11 sends `xo_lp`. The pair `sel_l`=00 with `sel_r`=01 places A left and B right.
- R8: `sel_r` codes: 00 sends `ch_a`, 01 sends `ch_b`, 10 sends `ch_sub`, 11 sends `xo_hp`.
- R9: Both selects and all source words are latched together once per frame, one bit period before the left MSB. A change in the middle of a frame first shows up in the next frame.
- R10: In digital mode with `fs96`=0, `aux_bclk` equals `sclk_in` delayed by one system clock. With `fs96`=1 it toggles on each rising edge of `sclk_in`, which gives half the input rate.
- R11: `aux_lrck` and `aux_sd` change only on a falling edge of `aux_bclk` while the port runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| analog_mode | input | 1 | 1 = analog-input mode (divided clock), 0 = digital-input mode |
| pd_adc | input | 1 | ADC power-down, gates outputs in analog mode |
| pd_all | input | 1 | Global power-down, gates outputs in analog mode |
| fs96 | input | 1 | Input frame rate is 96 kHz (halve the digital-mode rate) |
| sclk_in | input | 1 | Incoming serial bit clock, sampled by `clk` |
| sel_l | input | 2 | Left slot source select |
| sel_r | input | 2 | Right slot source select |
| ch_a | input | SAMPLE_W | Channel A sample |
| ch_b | input | SAMPLE_W | Channel B sample |
| ch_sub | input | SAMPLE_W | Sub channel sample |
| xo_lp | input | SAMPLE_W | Channel B crossover low-pass sample |
| xo_hp | input | SAMPLE_W | Channel B crossover high-pass sample |
| aux_bclk | output | 1 | Bit clock |
| aux_lrck | output | 1 | Frame clock |
| aux_sd | output | 1 | Serial data |

## Verification
The bench uses the default parameters: 24-bit samples, 32-bit slots and a divide-by-8 analog bit clock. One full frame is therefore 512 system clocks, which lets many complete frames and a mid-frame select change fit into a short run. Because the sample width is smaller than the slot width, the zero padding at the end of each slot is visible. With a divider of 8 the half-period is 4, so an off-by-one in the high time or in the period shows up as a count error. The 10-cycle bench `sclk_in` gives distinct 10- and 20-cycle bit periods for the two digital rates.

// File: rtl/aux_audio_tx.sv
module aux_audio_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int ANA_DIV  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                fmt_i2s,
  input  logic                analog_mode,
  input  logic                pd_adc,
  input  logic                pd_all,
  input  logic                fs96,
  input  logic                sclk_in,
  input  logic [1:0]          sel_l,
  input  logic [1:0]          sel_r,
  input  logic [SAMPLE_W-1:0] ch_a,
  input  logic [SAMPLE_W-1:0] ch_b,
  input  logic [SAMPLE_W-1:0] ch_sub,
  input  logic [SAMPLE_W-1:0] xo_lp,
  input  logic [SAMPLE_W-1:0] xo_hp,
  output logic                aux_bclk,
  output logic                aux_lrck,
  output logic                aux_sd
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int HALF       = ANA_DIV / 2;
  localparam int DIV_W      = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic                run;
  logic [DIV_W-1:0]    div_q;
  logic                sclk_q, bclk_q, lrck_q, sd_q;
  logic [CNT_W-1:0]    pos_q, pos_nx;
  logic [SAMPLE_W-1:0] word_l, word_r, mux_l, mux_r;
  logic                ana_tick, bclk_nx, fall, capture, slot_nx, lrck_nx, sd_nx;
  int                  bit_idx;

  assign run      = en && !(analog_mode && (pd_adc || pd_all));
  assign ana_tick = (div_q == DIV_W'(HALF - 1));

  always_comb begin
    if (analog_mode)  bclk_nx = ana_tick ? ~bclk_q : bclk_q;
    else if (fs96)    bclk_nx = (sclk_in && !sclk_q) ? ~bclk_q : bclk_q;
    else              bclk_nx = sclk_in;
  end

  assign fall    = bclk_q && !bclk_nx;
  assign pos_nx  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  assign slot_nx = (pos_nx >= CNT_W'(SLOT_W));
  assign capture = !run || (fall && pos_q == CNT_W'(FRAME_BITS - 2));

  always_comb begin
    case (sel_l)
      2'd0:    mux_l = ch_a;
      2'd1:    mux_l = ch_b;
      2'd2:    mux_l = ch_sub;
      default: mux_l = xo_lp;
    endcase
    case (sel_r)
      2'd0:    mux_r = ch_a;
      2'd1:    mux_r = ch_b;
      2'd2:    mux_r = ch_sub;
      default: mux_r = xo_hp;
    endcase
  end

  always_comb begin
    bit_idx = slot_nx ? int'(pos_nx) - SLOT_W : int'(pos_nx);
    sd_nx   = 1'b0;
    if (bit_idx < SAMPLE_W)
      sd_nx = slot_nx ? word_r[SAMPLE_W-1-bit_idx] : word_l[SAMPLE_W-1-bit_idx];
    if (fmt_i2s)
      lrck_nx = (pos_nx >= CNT_W'(SLOT_W - 1)) && (pos_nx <= CNT_W'(FRAME_BITS - 2));
    else
      lrck_nx = !slot_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      div_q  <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      sd_q   <= 1'b0;
      pos_q  <= LAST_POS;
      word_l <= '0;
      word_r <= '0;
    end else begin
      sclk_q <= sclk_in;
      if (capture) begin
        word_l <= mux_l;
        word_r <= mux_r;
      end
      if (!run) begin
        div_q  <= '0;
        bclk_q <= 1'b0;
        lrck_q <= 1'b0;
        sd_q   <= 1'b0;
        pos_q  <= LAST_POS;
      end else begin
        div_q  <= (analog_mode && !ana_tick) ? div_q + 1'b1 : '0;
        bclk_q <= bclk_nx;
        if (fall) begin
          pos_q  <= pos_nx;
          lrck_q <= lrck_nx;
          sd_q   <= sd_nx;
        end
      end
    end
  end

  assign aux_bclk = bclk_q;
  assign aux_lrck = lrck_q;
  assign aux_sd   = sd_q;

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!aux_bclk && !aux_lrck && !aux_sd));

  p_pwrdn_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && analog_mode && (pd_adc || pd_all)) |=> (!aux_bclk && !aux_lrck && !aux_sd));

  p_follow_sclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(analog_mode) && !$past(fs96)) |-> (aux_bclk == $past(sclk_in)));

  p_change_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (aux_sd != $past(aux_sd) || aux_lrck != $past(aux_lrck)))
      |-> ($past(aux_bclk) && !aux_bclk));
endmodule

// File: tb/aux_audio_tx_bench.sv
module aux_audio_tx_bench;
  localparam int SW  = 24;
  localparam int SLW = 32;
  localparam int DIV = 8;
  localparam int FB  = 2 * SLW;

  localparam logic [SW-1:0] SA = 24'h800001;
  localparam logic [SW-1:0] SB = 24'h7FFFFE;
  localparam logic [SW-1:0] SS = 24'h123456;
  localparam logic [SW-1:0] SL = 24'hC0FFEE;
  localparam logic [SW-1:0] SH = 24'h0A5A5A;

  // {fmt_i2s, sel_l, sel_r, expected left, expected right}
  localparam int NV = 7;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd1, SA, SB},
    {1'b1, 2'd0, 2'd1, SA, SB},
    {1'b0, 2'd2, 2'd3, SS, SH},
    {1'b1, 2'd3, 2'd2, SL, SS},
    {1'b0, 2'd1, 2'd0, SB, SA},
    {1'b1, 2'd3, 2'd3, SL, SH},
    {1'b0, 2'd2, 2'd0, SS, SA}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, fmt_i2s = 1'b0, analog_mode = 1'b1;
  logic pd_adc = 1'b0, pd_all = 1'b0, fs96 = 1'b0, sclk_in = 1'b0;
  logic [1:0] sel_l = 2'd0, sel_r = 2'd1;
  logic [SW-1:0] ch_a = SA, ch_b = SB, ch_sub = SS, xo_lp = SL, xo_hp = SH;
  logic aux_bclk, aux_lrck, aux_sd;

  aux_audio_tx #(.SAMPLE_W(SW), .SLOT_W(SLW), .ANA_DIV(DIV)) u_aux_audio_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt_i2s(fmt_i2s), .analog_mode(analog_mode),
    .pd_adc(pd_adc), .pd_all(pd_all), .fs96(fs96), .sclk_in(sclk_in),
    .sel_l(sel_l), .sel_r(sel_r), .ch_a(ch_a), .ch_b(ch_b), .ch_sub(ch_sub),
    .xo_lp(xo_lp), .xo_hp(xo_hp), .aux_bclk(aux_bclk), .aux_lrck(aux_lrck), .aux_sd(aux_sd)
  );

  int checks = 0;
  int errs   = 0;
  logic gen_on = 1'b0;
  logic dbits [0:255];
  logic lbits [0:255];

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        cnt++;
        if (cnt == 5) begin
          sclk_in = ~sclk_in;
          cnt = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic pb, got;
    pb = aux_bclk;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = aux_bclk && !pb;
      pb = aux_bclk;
    end
  endtask

  task automatic grab(input int from, input int n);
    for (int i = from; i < from + n; i++) begin
      wait_rise();
      lbits[i] = aux_lrck;
      dbits[i] = aux_sd;
    end
  endtask

  task automatic start_analog(input logic f, input logic [1:0] sl, input logic [1:0] sr);
    en = 1'b0;
    repeat (3) @(negedge clk);
    analog_mode = 1'b1;
    fmt_i2s = f;
    sel_l = sl;
    sel_r = sr;
    @(negedge clk);
    en = 1'b1;
    wait_rise();
  endtask

  task automatic check_frame(input int base, input logic f, input logic [SW-1:0] el,
                             input logic [SW-1:0] er);
    logic [SW-1:0] al, ar;
    logic [63:0] alr, elr;
    logic pad;
    pad = 1'b0;
    for (int i = 0; i < SW; i++) begin
      al[SW-1-i] = dbits[base + i];
      ar[SW-1-i] = dbits[base + SLW + i];
    end
    for (int i = SW; i < SLW; i++) pad = pad | dbits[base + i] | dbits[base + SLW + i];
    for (int p = 0; p < FB; p++) begin
      alr[p] = lbits[base + p];
      elr[p] = f ? (p >= SLW - 1 && p <= FB - 2) : (p < SLW);
    end
    chk("R7 left slot word", 64'(al), 64'(el));
    chk("R8 right slot word", 64'(ar), 64'(er));
    if (f) chk("R6 I2S frame clock pattern", alr, elr);
    else   chk("R5 LJ frame clock pattern", alr, elr);
    chk("R5 slot padding zero", 64'(pad), 64'd0);
  endtask

  task automatic zero_for(input int n, output logic ok);
    ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (aux_bclk || aux_lrck || aux_sd) ok = 1'b0;
    end
  endtask

  task automatic rise_gap(output int g);
    logic pb, got;
    wait_rise();
    pb = 1'b1;
    got = 1'b0;
    g = 0;
    while (!got) begin
      @(negedge clk);
      g++;
      got = aux_bclk && !pb;
      pb = aux_bclk;
    end
  endtask

  task automatic lrck_gap(output int g);
    logic pb, got;
    pb = aux_lrck;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = aux_lrck && !pb;
      pb = aux_lrck;
    end
    got = 1'b0;
    g = 0;
    while (!got) begin
      @(negedge clk);
      g++;
      got = aux_lrck && !pb;
      pb = aux_lrck;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    logic ok;
    int g;
    repeat (4) @(negedge clk);
    chk("R1 outputs low in reset", {61'd0, aux_bclk, aux_lrck, aux_sd}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      start_analog(VEC[v][52], VEC[v][51:50], VEC[v][49:48]);
      grab(0, FB);
      check_frame(0, VEC[v][52], VEC[v][47:24], VEC[v][23:0]);
    end

    // R9: mid-frame select change takes effect next frame
    start_analog(1'b0, 2'd0, 2'd1);
    grab(0, 16);
    sel_l = 2'd2;
    sel_r = 2'd3;
    grab(16, FB - 16 + FB);
    check_frame(0, 1'b0, SA, SB);
    check_frame(FB, 1'b0, SS, SH);
    chk("R9 old selection kept in current frame", 64'(dbits[0]), 64'(SA[SW-1]));

    // R3 / R4 analog timing
    rise_gap(g);
    chk("R3 analog bit clock period", 64'(g), 64'(DIV));
    wait_rise();
    g = 0;
    while (aux_bclk) begin
      @(negedge clk);
      g++;
    end
    chk("R3 analog bit clock high time", 64'(g), 64'(DIV / 2));
    lrck_gap(g);
    chk("R4 analog frame length", 64'(g), 64'(FB * DIV));

    // R1 disable holds outputs low
    en = 1'b0;
    @(negedge clk);
    zero_for(40, ok);
    chk("R1 disabled outputs low", 64'(ok), 64'd1);

    // R2 analog power-down
    pd_adc = 1'b1;
    en = 1'b1;
    @(negedge clk);
    zero_for(40, ok);
    chk("R2 pd_adc forces low", 64'(ok), 64'd1);
    pd_adc = 1'b0;
    pd_all = 1'b1;
    @(negedge clk);
    zero_for(40, ok);
    chk("R2 pd_all forces low", 64'(ok), 64'd1);

    // R10 digital rates; R2 power-down ignored in digital mode
    en = 1'b0;
    @(negedge clk);
    analog_mode = 1'b0;
    fs96 = 1'b0;
    gen_on = 1'b1;
    @(negedge clk);
    en = 1'b1;
    rise_gap(g);
    chk("R2 digital mode ignores power-down", 64'(g), 64'd10);
    pd_all = 1'b0;
    rise_gap(g);
    chk("R10 digital full-rate bit period", 64'(g), 64'd10);
    lrck_gap(g);
    chk("R4 digital frame length", 64'(g), 64'(FB * 10));
    en = 1'b0;
    @(negedge clk);
    fs96 = 1'b1;
    @(negedge clk);
    en = 1'b1;
    rise_gap(g);
    chk("R10 digital half-rate bit period", 64'(g), 64'd20);
    en = 1'b0;
    gen_on = 1'b0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule